// File: doc/BRIEF.md
# Watchdog Supervisor with Alert Pulse

This block watches a periodic "kick" from a processor and drives an active-low alert when the kicks stop. A kick clears an internal timeout counter. If the counter reaches the timeout period without being cleared, the alert goes low. Both the kick input and a disable input are asynchronous. Each passes through a two-flop synchroniser and a pulse-width filter before the timing logic sees it. Releasing reset counts as power becoming good: counting starts from zero and the alert is high.

One compile-time parameter selects between two alert behaviours.

- **Long mode:** both edges of the kick count as a clear. Once the alert asserts, it stays low for a fixed pulse length and ignores kicks.
- **Short mode:** only rising kick edges clear the counter. An unattended alert lasts one timeout period and then repeats after another timeout period. A kick during the alert ends it early.

In both modes, an early release caused by a kick or by the disable input waits until the alert has been low for a guaranteed minimum width. Every change of the alert output restarts the timeout count from zero.

All durations are parameters in clock cycles. The defaults correspond to a 10 MHz clock: a 3.4 ms timeout, a 210 ms pulse, a 10 µs minimum width, and a filter that rejects pulses shorter than 100 ns and accepts pulses of 1 µs.

Top module: `wdt_supervisor`

## Requirements
- R1: With no clear, `alert_no` falls TIMEOUT_CYC cycles after the last clear. A clear is one of: reset release, a qualified kick edge, an alert transition, or disable falling. After reset release at edge R, the fall happens at edge R+TIMEOUT_CYC.
- R2: In long mode (MODE=1), both rising and falling qualified kick edges clear the timeout counter. In short mode (MODE=0), only rising edges clear it, and a falling edge has no effect on when the next alert falls.
- R3: In long mode, `alert_no` stays low for exactly PULSE_CYC cycles, whatever the kick input does during that time.
- R4: In short mode with no kicks, `alert_no` alternates between TIMEOUT_CYC cycles low and TIMEOUT_CYC cycles high.
- R5: In short mode, a qualified rising kick during the alert releases it. The release happens in the cycle the kick takes effect, but no earlier than MIN_W_CYC cycles after the fall. A kick that arrives earlier is remembered and releases the alert exactly at MIN_W_CYC.
- R6: While disable is high and the alert is high, the alert stays high and the count is held at zero. After disable falls, the next alert falls TIMEOUT_CYC cycles after the qualified disable clears.
- R7: If disable rises during an alert, the alert releases no earlier than MIN_W_CYC cycles after its fall. This applies in both modes.
- R8: An input pulse held for fewer than FILT_CYC clock cycles is ignored. A pulse held for at least FILT_CYC cycles is accepted. A kick change driven before edge N+1 clears the counter at edge N+FILT_CYC+3, and a disable fall clears it from edge N+FILT_CYC+2.
- R9: During reset `alert_no` is high.
- R10: After any alert release, the next fall comes TIMEOUT_CYC cycles later unless a clear intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, standing in for power-good |
| kick_i | input | 1 | Asynchronous watchdog kick |
| disable_i | input | 1 | Asynchronous disable, active high |
| alert_no | output | 1 | Watchdog alert, active low |

## Verification
Some properties are checked by assertions on every cycle:
- the timeout counter never reaches its limit;
- the counter is zero on each alert transition;
- no alert releases before its minimum width;
- a long-mode pulse ends only at full length or through disable;
- disable keeps a released alert high;
- the filter changes its output only after a stable synchronised input.

Other behaviours need the bench's scenarios, because they depend on cycle positions relative to driven stimulus:
- the exact fall and rise positions after kicks;
- which kick edges count in each mode;
- rejection of short pulses;
- the remembered early kick.

The bench runs both modes side by side and predicts every edge arithmetically from the parameters.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } alert_mode_e;

  // bits needed to hold values 0..n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdt_in_qual.sv
module wdt_in_qual #(
  parameter int unsigned FILT_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic qual_o
);
  localparam int unsigned FW = wdt_pkg::cnt_w(FILT_CYC);
  localparam logic [FW-1:0] FILT_M1 = FW'(FILT_CYC - 1);

  logic       meta_q, sync_q;
  logic       qual_q;
  logic [FW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  // output follows sync only after FILT_CYC consecutive mismatching samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= 1'b0;
      run_q  <= '0;
    end else if (sync_q == qual_q) begin
      run_q <= '0;
    end else if (run_q == FILT_M1) begin
      qual_q <= sync_q;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = qual_q;

  generate
    if (FILT_CYC >= 2) begin : g_filt_chk
      p_filt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qual_q != $past(qual_q)) |-> ($past(sync_q, 1) == qual_q && $past(sync_q, 2) == qual_q))
        else $error("p_filt_hold_r8");
    end
  endgenerate

endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; #(
  parameter alert_mode_e MODE        = MODE_LONG,
  parameter int unsigned TIMEOUT_CYC = 34000,
  parameter int unsigned PULSE_CYC   = 2100000,
  parameter int unsigned MIN_W_CYC   = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic dis_i,
  output logic alert_o
);
  localparam int unsigned END_CYC = (MODE == MODE_LONG) ? PULSE_CYC : TIMEOUT_CYC;
  localparam int unsigned TW = cnt_w(TIMEOUT_CYC);
  localparam int unsigned AW = cnt_w(END_CYC);
  localparam logic [TW-1:0] TO_M1  = TW'(TIMEOUT_CYC - 1);
  localparam logic [AW-1:0] END_M1 = AW'(END_CYC - 1);
  localparam logic [AW-1:0] MIN_M1 = AW'(MIN_W_CYC - 1);

  logic          kick_q;
  logic          alert_q, alert_d;
  logic          pend_q, pend_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [AW-1:0] acnt_q, acnt_d;
  logic          kick_ev, rel_req;

  assign kick_ev = (MODE == MODE_LONG) ? (kick_i ^ kick_q) : (kick_i & ~kick_q);

  always_comb begin
    alert_d = alert_q;
    pend_d  = 1'b0;
    tcnt_d  = '0;
    acnt_d  = '0;
    rel_req = 1'b0;
    if (!alert_q) begin
      if (dis_i || kick_ev) begin
        tcnt_d = '0;
      end else if (tcnt_q == TO_M1) begin
        alert_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end else begin
      rel_req = dis_i | pend_q | ((MODE == MODE_SHORT) & kick_ev);
      if (acnt_q == END_M1 || (rel_req && acnt_q >= MIN_M1)) begin
        alert_d = 1'b0;
      end else begin
        acnt_d = acnt_q + 1'b1;
        pend_d = rel_req;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_q  <= 1'b0;
      alert_q <= 1'b0;
      pend_q  <= 1'b0;
      tcnt_q  <= '0;
      acnt_q  <= '0;
    end else begin
      kick_q  <= kick_i;
      alert_q <= alert_d;
      pend_q  <= pend_d;
      tcnt_q  <= tcnt_d;
      acnt_q  <= acnt_d;
    end
  end

  assign alert_o = alert_q;

  p_tcnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt_q <= TO_M1) else $error("p_tcnt_bound_r1");

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_q != $past(alert_q)) |-> (tcnt_q == '0)) else $error("p_restart_r10");

  p_min_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_q) |-> ($past(acnt_q) >= MIN_M1)) else $error("p_min_width_r5");

  p_dis_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !alert_q) |=> !alert_q) else $error("p_dis_quiet_r6");

  generate
    if (MODE == MODE_LONG) begin : g_long_chk
      p_long_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(alert_q) |-> ($past(acnt_q) == END_M1 || $past(dis_i) || $past(pend_q)))
        else $error("p_long_len_r3");
    end
  endgenerate

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor import wdt_pkg::*; #(
  parameter alert_mode_e MODE        = MODE_LONG,
  parameter int unsigned TIMEOUT_CYC = 34000,
  parameter int unsigned PULSE_CYC   = 2100000,
  parameter int unsigned MIN_W_CYC   = 100,
  parameter int unsigned FILT_CYC    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic disable_i,
  output logic alert_no
);
  localparam int unsigned N_IN = 2;

  logic [N_IN-1:0] raw_in, qual_in;
  logic            alert;

  assign raw_in = {disable_i, kick_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    wdt_in_qual #(.FILT_CYC(FILT_CYC)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_in[i]),
      .qual_o (qual_in[i])
    );
  end

  wdt_core #(
    .MODE        (MODE),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .MIN_W_CYC   (MIN_W_CYC)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (qual_in[0]),
    .dis_i   (qual_in[1]),
    .alert_o (alert)
  );

  assign alert_no = ~alert;

endmodule

// File: tb/wdt_supervisor_bench.sv
`timescale 1ns/1ps
module wdt_supervisor_bench;
  import wdt_pkg::*;

  localparam int T    = 40;
  localparam int P    = 100;
  localparam int MINW = 12;
  localparam int FILT = 4;
  localparam int LAT  = FILT + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic kick_l = 1'b0, dis_l = 1'b0, kick_s = 1'b0, dis_s = 1'b0;
  logic alert_l, alert_s;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int l_fall = 0, l_rise = 0, s_fall = 0, s_rise = 0;
  int l_nf = 0, s_nf = 0;
  logic l_prev = 1'b1, s_prev = 1'b1;
  int r0, n, f, r, nf0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_supervisor #(.MODE(MODE_LONG), .TIMEOUT_CYC(T), .PULSE_CYC(P),
                   .MIN_W_CYC(MINW), .FILT_CYC(FILT)) u_wdt_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .kick_i(kick_l), .disable_i(dis_l), .alert_no(alert_l));

  wdt_supervisor #(.MODE(MODE_SHORT), .TIMEOUT_CYC(T), .PULSE_CYC(P),
                   .MIN_W_CYC(MINW), .FILT_CYC(FILT)) u_wdt_supervisor_short (
    .clk_i(clk), .rst_ni(rst_ni), .kick_i(kick_s), .disable_i(dis_s), .alert_no(alert_s));

  always @(negedge clk) begin
    if (alert_l != l_prev) begin
      if (!alert_l) begin l_fall = cyc; l_nf++; end else l_rise = cyc;
      l_prev = alert_l;
    end
    if (alert_s != s_prev) begin
      if (!alert_s) begin s_fall = cyc; s_nf++; end else s_rise = cyc;
      s_prev = alert_s;
    end
  end

  task automatic step(input int k = 1);
    for (int i = 0; i < k; i++) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_l(input logic v);
    while (alert_l !== v) step();
  endtask

  task automatic wait_s(input logic v);
    while (alert_s !== v) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R9 long reset", int'(alert_l), 1);
    chk("R9 short reset", int'(alert_s), 1);
    r0 = cyc;
    rst_ni = 1'b1;

    // short mode free run
    wait_s(0);
    chk("R1 short first fall", s_fall, r0 + T);
    wait_s(1);
    chk("R4 short low width", s_rise, s_fall + T);
    wait_s(0);
    chk("R4 R10 short high width", s_fall, s_rise + T);
    chk("R1 long first fall", l_fall, r0 + T);

    // long mode: kicks during alert ignored
    kick_l = 1'b1; step(6); kick_l = 1'b0; step(6);
    wait_l(1);
    chk("R3 long pulse width with kicks", l_rise, l_fall + P);

    // both edges clear in long mode
    step(5); kick_l = 1'b1; step(20); n = cyc; kick_l = 1'b0;
    wait_l(0);
    chk("R2 long falling edge clears", l_fall, n + LAT + T);

    // glitch rejected
    wait_l(1);
    chk("R3 long pulse width", l_rise, l_fall + P);
    r = l_rise;
    step(5); kick_l = 1'b1; step(FILT - 1); kick_l = 1'b0;
    wait_l(0);
    chk("R8 short pulse rejected", l_fall, r + T);

    // minimum pulse accepted
    wait_l(1);
    step(5); n = cyc; kick_l = 1'b1; step(FILT); kick_l = 1'b0;
    wait_l(0);
    chk("R8 min pulse accepted", l_fall, n + FILT + LAT + T);

    // disable holds off alert
    wait_l(1);
    step(5); dis_l = 1'b1; nf0 = l_nf;
    step(200);
    chk("R6 disable holds alert high", int'(alert_l), 1);
    chk("R6 no fall while disabled", l_nf, nf0);
    n = cyc; dis_l = 1'b0;
    wait_l(0);
    chk("R6 restart after disable", l_fall, n + LAT - 1 + T);

    // disable during alert: release at min width
    f = cyc; dis_l = 1'b1;
    wait_l(1);
    chk("R7 disable release at min width", l_rise, f + MINW);
    nf0 = l_nf; step(50);
    chk("R7 stays high while disabled", l_nf, nf0);
    n = cyc; dis_l = 1'b0;
    wait_l(0);
    chk("R6 restart after disable in alert", l_fall, n + LAT - 1 + T);

    // short mode: early kick remembered until min width
    wait_s(1); wait_s(0);
    f = cyc; kick_s = 1'b1;
    wait_s(1);
    chk("R5 early kick held to min width", s_rise, f + MINW);
    r = s_rise;
    step(10); kick_s = 1'b0;
    wait_s(0);
    chk("R2 R10 short falling edge ignored", s_fall, r + T);

    // late kick releases immediately
    step(20); n = cyc; kick_s = 1'b1;
    wait_s(1);
    chk("R5 late kick releases", s_rise, n + LAT);
    r = s_rise;
    step(5); kick_s = 1'b0;
    wait_s(0);
    chk("R10 short restart after release", s_fall, r + T);
    wait_s(1);
    chk("R4 short unattended low width", s_rise, s_fall + T);

    // short mode rising kick while high clears
    step(10); n = cyc; kick_s = 1'b1; step(FILT + 2); kick_s = 1'b0;
    wait_s(0);
    chk("R2 short rising edge clears", s_fall, n + LAT + T);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule